// File: doc/BRIEF.md
# Slicer-Embedding Receive Sample Formatter

This block sits downstream of a digital gain stage that makes up for attenuation in the analog front end. Large compensation gains leave each I/Q sample far wider than the 12-bit output word. The block scales both components down by a selectable number of 6 dB steps and rounds the result. It clamps the value so that it fits the data field, and then writes the step code into spare bit positions of the I and Q words. The receiver can therefore undo the scaling sample by sample without a side channel.

A per-sample configuration chooses one or two code bits per component and places them either at the top or at the bottom of each word. The code, the configuration and the sample are captured together, so every output pair carries data and a code that agree. The output is a valid-qualified I/Q pair that appears a fixed two cycles after its input.

Top module: `slc_embed_fmt`

## Requirements
- R1: While `rst_n` is low, and after reset until the first valid sample has passed through, `out_vld` is 0 and both output words are 0.
- R2: `out_vld` is high exactly two clock edges after a cycle with `in_vld` high, and low two edges after a cycle with `in_vld` low. Both output words are 0 in every cycle where `out_vld` is low.
- R3: The shift count k is `slc_code[1:0]` in one-bit mode and `slc_code[3:0]` in two-bit mode. Each component becomes floor((x + 2^(k-1)) / 2^k) for k > 0 (rounding halves upward), and stays x when k = 0.
- R4: A scaled value outside the signed range of the data field (11 bits in one-bit mode, 10 bits in two-bit mode) is clamped to that field's largest or smallest value and never wraps.
- R5: One-bit mode (`cfg_two_bit`=0): the I word carries `slc_code[1]` and the Q word carries `slc_code[0]`, each with 11 data bits. `slc_code[3:2]` has no effect on either output word.
- R6: Two-bit mode (`cfg_two_bit`=1): the I word carries `slc_code[3:2]` and the Q word carries `slc_code[1:0]`, each with 10 data bits.
- R7: With `cfg_msb`=1 the code bits occupy the top of the word, in the same bit order, and the data field sits below them. With `cfg_msb`=0 the code bits occupy bit 0 upward, and the data field sits above them.
- R8: Code and configuration are sampled in the same cycle as their sample. A change on the next cycle affects only the next output pair, even when samples arrive back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input pair valid |
| in_i | input | IN_W (24) | Gain-compensated I sample, signed |
| in_q | input | IN_W (24) | Gain-compensated Q sample, signed |
| slc_code | input | 4 | Slicer step code |
| cfg_two_bit | input | 1 | 1: two code bits per component, 0: one |
| cfg_msb | input | 1 | 1: code bits at the MSB end, 0: at the LSB end |
| out_vld | output | 1 | Output pair valid |
| out_i | output | OUT_W (12) | I word with embedded code bits |
| out_q | output | OUT_W (12) | Q word with embedded code bits |

## Verification
Every result in this block is due on the second rising edge after the input cycle: the valid flag, the scaled and clamped data, and the embedded code. The bench drives inputs on falling edges. It keeps a two-deep queue of expected pairs, and on each falling edge it compares the outputs against the entry queued two steps earlier. Back-to-back code changes and gaps in the valid stream therefore land on the exact pair they belong to. The checker properties use the same fixed two-cycle offset to compare code bits with the code presented at the input.

// File: rtl/slc_pkg.sv
package slc_pkg;

    localparam int EMB_MAX  = 2;
    localparam int CODE_W   = 2 * EMB_MAX;
    localparam int LANES    = 2;

    typedef enum logic {
        EMB_AT_LSB = 1'b0,
        EMB_AT_MSB = 1'b1
    } emb_pos_e;

    // lane 0 (I) takes the high half of the code, lane 1 (Q) the low half
    function automatic logic [EMB_MAX-1:0] lane_emb(
        input logic [CODE_W-1:0] code,
        input logic              two_bit,
        input int                lane
    );
        logic [EMB_MAX-1:0] r;
        if (two_bit)
            r = (lane == 0) ? code[3:2] : code[1:0];
        else
            r = (lane == 0) ? {1'b0, code[1]} : {1'b0, code[0]};
        return r;
    endfunction

    function automatic logic [CODE_W-1:0] shift_amt(
        input logic [CODE_W-1:0] code,
        input logic              two_bit
    );
        return two_bit ? code : {2'b00, code[1:0]};
    endfunction

endpackage

// File: rtl/slc_shift_sat.sv
module slc_shift_sat #(
    parameter int IN_W  = 24,
    parameter int OUT_W = 12
) (
    input  logic [IN_W-1:0]            smp,
    input  logic [slc_pkg::CODE_W-1:0] shamt,
    input  logic                       two_bit,
    output logic [OUT_W-1:0]           val
);
    localparam int XW = IN_W + 1;
    localparam logic signed [XW-1:0] HI_ONE = XW'((1 << (OUT_W - 2)) - 1);
    localparam logic signed [XW-1:0] LO_ONE = ~HI_ONE;
    localparam logic signed [XW-1:0] HI_TWO = XW'((1 << (OUT_W - 3)) - 1);
    localparam logic signed [XW-1:0] LO_TWO = ~HI_TWO;

    logic signed [XW-1:0] ext, half, sum, shf, hi, lo, sat;

    always_comb begin
        ext  = {smp[IN_W-1], smp};
        half = (shamt == '0) ? '0 : (XW'(1) << (shamt - 4'd1));
        sum  = ext + half;
        shf  = sum >>> shamt;
        hi   = two_bit ? HI_TWO : HI_ONE;
        lo   = two_bit ? LO_TWO : LO_ONE;
        if (shf > hi)
            sat = hi;
        else if (shf < lo)
            sat = lo;
        else
            sat = shf;
        val = sat[OUT_W-1:0];
    end

endmodule

// File: rtl/slc_pack.sv
module slc_pack #(
    parameter int OUT_W = 12
) (
    input  logic [OUT_W-1:0]            val,
    input  logic [slc_pkg::EMB_MAX-1:0] emb,
    input  logic                        two_bit,
    input  slc_pkg::emb_pos_e           pos,
    output logic [OUT_W-1:0]            word
);
    localparam int DW1 = OUT_W - 1;
    localparam int DW2 = OUT_W - 2;

    always_comb begin
        unique case ({two_bit, pos})
            {1'b0, slc_pkg::EMB_AT_MSB}: word = {emb[0], val[DW1-1:0]};
            {1'b0, slc_pkg::EMB_AT_LSB}: word = {val[DW1-1:0], emb[0]};
            {1'b1, slc_pkg::EMB_AT_MSB}: word = {emb, val[DW2-1:0]};
            default:                     word = {val[DW2-1:0], emb};
        endcase
    end

endmodule

// File: rtl/slc_embed_fmt.sv
module slc_embed_fmt #(
    parameter int IN_W  = 24,
    parameter int OUT_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_vld,
    input  logic [IN_W-1:0]            in_i,
    input  logic [IN_W-1:0]            in_q,
    input  logic [slc_pkg::CODE_W-1:0] slc_code,
    input  logic                       cfg_two_bit,
    input  logic                       cfg_msb,
    output logic                       out_vld,
    output logic [OUT_W-1:0]           out_i,
    output logic [OUT_W-1:0]           out_q
);
    import slc_pkg::*;

    typedef struct packed {
        logic              s1_vld;
        logic [IN_W-1:0]   s1_i;
        logic [IN_W-1:0]   s1_q;
        logic [CODE_W-1:0] s1_code;
        logic              s1_two;
        emb_pos_e          s1_pos;
        logic              o_vld;
        logic [OUT_W-1:0]  o_i;
        logic [OUT_W-1:0]  o_q;
    } fmt_st_t;

    fmt_st_t st_d, st_q;

    logic [IN_W-1:0]    lane_smp  [LANES];
    logic [OUT_W-1:0]   lane_val  [LANES];
    logic [OUT_W-1:0]   lane_word [LANES];
    logic [EMB_MAX-1:0] lane_bits [LANES];
    logic [CODE_W-1:0]  shamt;

    assign lane_smp[0] = st_q.s1_i;
    assign lane_smp[1] = st_q.s1_q;
    assign shamt       = shift_amt(st_q.s1_code, st_q.s1_two);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bits[g] = lane_emb(st_q.s1_code, st_q.s1_two, g);

        slc_shift_sat #(.IN_W(IN_W), .OUT_W(OUT_W)) u_scale (
            .smp     (lane_smp[g]),
            .shamt   (shamt),
            .two_bit (st_q.s1_two),
            .val     (lane_val[g])
        );

        slc_pack #(.OUT_W(OUT_W)) u_pack (
            .val     (lane_val[g]),
            .emb     (lane_bits[g]),
            .two_bit (st_q.s1_two),
            .pos     (st_q.s1_pos),
            .word    (lane_word[g])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.s1_vld = in_vld;
        if (in_vld) begin
            st_d.s1_i    = in_i;
            st_d.s1_q    = in_q;
            st_d.s1_code = slc_code;
            st_d.s1_two  = cfg_two_bit;
            st_d.s1_pos  = emb_pos_e'(cfg_msb);
        end
        st_d.o_vld = st_q.s1_vld;
        st_d.o_i   = st_q.s1_vld ? lane_word[0] : '0;
        st_d.o_q   = st_q.s1_vld ? lane_word[1] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_vld = st_q.o_vld;
    assign out_i   = st_q.o_i;
    assign out_q   = st_q.o_q;

endmodule

// File: rtl/slc_embed_fmt_chk.sv
module slc_embed_fmt_chk #(
    parameter int OUT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic [3:0]       slc_code,
    input logic             cfg_two_bit,
    input logic             cfg_msb,
    input logic             out_vld,
    input logic [OUT_W-1:0] out_i,
    input logic [OUT_W-1:0] out_q
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && out_i == '0 && out_q == '0));

    // R2
    vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> ##2 out_vld);

    // R2
    idle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |-> ##2 !out_vld);

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_i == '0 && out_q == '0));

    // R5
    one_msb_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !cfg_two_bit && cfg_msb) |-> ##2
        (out_i[OUT_W-1] == $past(slc_code[1], 2) && out_q[OUT_W-1] == $past(slc_code[0], 2)));

    // R7
    one_lsb_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !cfg_two_bit && !cfg_msb) |-> ##2
        (out_i[0] == $past(slc_code[1], 2) && out_q[0] == $past(slc_code[0], 2)));

    // R6
    two_msb_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && cfg_two_bit && cfg_msb) |-> ##2
        (out_i[OUT_W-1:OUT_W-2] == $past(slc_code[3:2], 2) &&
         out_q[OUT_W-1:OUT_W-2] == $past(slc_code[1:0], 2)));

    // R8
    two_lsb_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && cfg_two_bit && !cfg_msb) |-> ##2
        (out_i[1:0] == $past(slc_code[3:2], 2) && out_q[1:0] == $past(slc_code[1:0], 2)));

endmodule

bind slc_embed_fmt slc_embed_fmt_chk #(.OUT_W(OUT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_vld      (in_vld),
    .slc_code    (slc_code),
    .cfg_two_bit (cfg_two_bit),
    .cfg_msb     (cfg_msb),
    .out_vld     (out_vld),
    .out_i       (out_i),
    .out_q       (out_q)
);

// File: tb/sim_slc_embed_fmt.sv
module sim_slc_embed_fmt;
    localparam int IN_W  = 24;
    localparam int OUT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_vld = 1'b0;
    logic [IN_W-1:0]  in_i = '0;
    logic [IN_W-1:0]  in_q = '0;
    logic [3:0]       slc_code = '0;
    logic             cfg_two_bit = 1'b0;
    logic             cfg_msb = 1'b0;
    logic             out_vld;
    logic [OUT_W-1:0] out_i, out_q;

    int compared = 0;
    int mismatched = 0;

    // expected pairs: a = queued last step, b = queued two steps ago
    logic [2*OUT_W:0] exp_a = '0;
    logic [2*OUT_W:0] exp_b = '0;
    string            tag_a = "R2";
    string            tag_b = "R2";

    always #4 clk = ~clk;

    slc_embed_fmt #(.IN_W(IN_W), .OUT_W(OUT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
        .slc_code(slc_code), .cfg_two_bit(cfg_two_bit), .cfg_msb(cfg_msb),
        .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
    );

    function automatic logic [OUT_W-1:0] model(input logic [IN_W-1:0] x, input logic [3:0] code,
                                               input logic two, input logic msb, input int lane);
        longint v, r, hi, lo, field, emb;
        int k, nb, dw;
        v  = longint'($signed(x));
        k  = two ? int'(code) : int'(code[1:0]);
        nb = two ? 2 : 1;
        dw = OUT_W - nb;
        if (k == 0) r = v;
        else r = (v + (longint'(1) <<< (k - 1))) >>> k;
        hi = (longint'(1) <<< (dw - 1)) - 1;
        lo = -hi - 1;
        if (r > hi) r = hi;
        if (r < lo) r = lo;
        field = r & ((longint'(1) <<< dw) - 1);
        if (two) emb = (lane == 0) ? longint'(code[3:2]) : longint'(code[1:0]);
        else     emb = (lane == 0) ? longint'(code[1])   : longint'(code[0]);
        if (msb) return OUT_W'((emb <<< dw) | field);
        return OUT_W'((field <<< nb) | emb);
    endfunction

    // one clock step: check the pair due now, then drive the next input
    task automatic step(input logic v, input logic [IN_W-1:0] xi, input logic [IN_W-1:0] xq,
                        input logic [3:0] code, input logic two, input logic msb,
                        input logic [3:0] mcode, input string tag);
        logic [2*OUT_W:0] got;
        @(negedge clk);
        got = {out_vld, out_i, out_q};
        compared++;
        if (got !== exp_b) begin
            mismatched++;
            $display("FAIL %s: vld/i/q got %0b/%h/%h expected %0b/%h/%h", tag_b,
                     got[2*OUT_W], got[2*OUT_W-1:OUT_W], got[OUT_W-1:0],
                     exp_b[2*OUT_W], exp_b[2*OUT_W-1:OUT_W], exp_b[OUT_W-1:0]);
        end
        exp_b = exp_a;
        tag_b = tag_a;
        if (v) exp_a = {1'b1, model(xi, mcode, two, msb, 0), model(xq, mcode, two, msb, 1)};
        else   exp_a = '0;
        tag_a = tag;
        in_vld = v; in_i = xi; in_q = xq; slc_code = code; cfg_two_bit = two; cfg_msb = msb;
    endtask

    task automatic put(input logic [IN_W-1:0] xi, input logic [IN_W-1:0] xq,
                       input logic [3:0] code, input logic two, input logic msb, input string tag);
        step(1'b1, xi, xq, code, two, msb, code, tag);
    endtask

    initial begin
        #400000;
        $display("FAIL watchdog: run did not end, got running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared + 1, mismatched + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: outputs quiet while reset is held
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            compared++;
            if (out_vld !== 1'b0 || out_i !== '0 || out_q !== '0) begin
                mismatched++;
                $display("FAIL R1: vld/i/q got %0b/%h/%h expected 0/000/000", out_vld, out_i, out_q);
            end
        end
        rst_n = 1'b1;
        tag_a = "R1"; tag_b = "R1";
        step(1'b0, '0, '0, 4'd0, 1'b0, 1'b0, 4'd0, "R1");

        // R3: rounding of halves, both signs
        put(24'sd3,  -24'sd3, 4'd1, 1'b1, 1'b0, "R3");
        put(24'sd1,  -24'sd1, 4'd1, 1'b1, 1'b0, "R3");
        put(24'sd6,  -24'sd6, 4'd2, 1'b1, 1'b1, "R3");
        put(24'sd100, -24'sd77, 4'd0, 1'b0, 1'b0, "R3");
        put(24'sd1000, -24'sd1000, 4'd3, 1'b0, 1'b1, "R3");
        // R4: clamping at both ends, both data widths
        put(24'h7FFFFF, 24'h800000, 4'd0, 1'b0, 1'b1, "R4");
        put(24'h7FFFFF, 24'h800000, 4'd15, 1'b1, 1'b0, "R4");
        put(24'sd1024, -24'sd1025, 4'd0, 1'b0, 1'b0, "R4");
        put(24'sd512, -24'sd513, 4'd0, 1'b1, 1'b1, "R4");
        // R5: upper code bits ignored in one-bit mode
        step(1'b1, 24'sd40000, -24'sd40000, 4'b1110, 1'b0, 1'b1, 4'b0010, "R5");
        step(1'b1, 24'sd40000, -24'sd40000, 4'b1101, 1'b0, 1'b0, 4'b0001, "R5");
        // R6, R7: every code in two-bit mode at both ends
        for (int c = 0; c < 16; c++) begin
            put(24'(c * 3001), 24'(-c * 2999), 4'(c), 1'b1, 1'(c & 1), (c & 1) ? "R7" : "R6");
        end
        // R8: code and placement change on every back-to-back sample
        for (int n = 0; n < 24; n++) begin
            put(24'(n * 777 - 9000), 24'(9000 - n * 555), 4'(n * 5), 1'(n % 3 == 0), 1'(n & 1), "R8");
        end
        // R2: gaps in the valid stream
        for (int n = 0; n < 60; n++) begin
            logic v;
            v = 1'($urandom % 2);
            step(v, 24'($urandom), 24'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
                 4'(0), "R2");
            if (v) exp_a = {1'b1, model(in_i, slc_code, cfg_two_bit, cfg_msb, 0),
                                  model(in_q, slc_code, cfg_two_bit, cfg_msb, 1)};
        end
        // R3 random mix of magnitudes and settings
        for (int n = 0; n < 1500; n++) begin
            logic [IN_W-1:0] xi, xq;
            xi = 24'($signed(24'($urandom)) >>> ($urandom % 24));
            xq = 24'($signed(24'($urandom)) >>> ($urandom % 24));
            put(xi, xq, 4'($urandom), 1'($urandom), 1'($urandom), "R3");
        end
        step(1'b0, '0, '0, 4'd0, 1'b0, 1'b0, 4'd0, "R2");
        step(1'b0, '0, '0, 4'd0, 1'b0, 1'b0, 4'd0, "R2");
        step(1'b0, '0, '0, 4'd0, 1'b0, 1'b0, 4'd0, "R2");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule